// File: doc/BRIEF.md
# UART FIFO Threshold Controller

This block sits between a UART's serial engines and the processor side. It holds a receive byte FIFO and a transmit byte FIFO, takes a write-only control word that turns the FIFOs on or off and can flush either of them, and sets two levels. One is the receive fill level at which service is requested. The other chooses whether transmit service is requested at half empty or only at empty. From the two occupancy counts, the interrupt enables and a DMA-mode input, it drives the receive and transmit interrupt lines, the two DMA request lines and a transmit-data-request status flag.

The control word and a read-only identification word share one bus address. A bus write updates the control word. The read port always presents the identification word. The transmit FIFO feeds an external shift register: whenever that shifter reports it is idle and a byte is queued, the block hands it one byte. A transmit flush only discards queued bytes. A character already inside the shifter is left to finish.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both FIFOs are empty and disabled. The receive level is 1 byte and the transmit level is half empty. `tx_data_req` is 1 and `bus_rdata` reads 32'h0000_0001.
- R2: `bus_rdata` is a placeholder identification word. Bits 7 and 6 both equal the FIFO-enable state, bit 0 is 1, and every other bit is 0. A write with `bus_wr` high loads the control word at the next clock edge.
- R3: Control bit 0 enables the FIFOs. While it is 0, each direction holds at most one byte, and pushes beyond that byte are dropped.
- R4: While the FIFOs are enabled, each FIFO holds up to 64 bytes in first-in first-out order. Pushes into a full FIFO are dropped.
- R5: Control bits 7:6 set the receive level: 00 is 1 byte, 01 is 8, 10 is 16 and 11 is 32. The level is 1 byte while the FIFOs are disabled. `rx_irq` is high when `rx_irq_en` is high and the receive count is at or above the level.
- R6: `rx_dma_req` is high when `dma_mode` is high, the FIFOs are enabled, bits 7:6 are not 00, and the receive count is at or above the level. With bits 7:6 at 00 it stays low.
- R7: Control bit 3 sets the transmit level. With bit 3 at 0, `tx_data_req` is high at a transmit count of 32 or fewer. With bit 3 at 1, or with the FIFOs disabled, it is high only at a count of 0. `tx_irq` is `tx_data_req` gated by `tx_irq_en`, and `tx_dma_req` is `tx_data_req` gated by `dma_mode`.
- R8: Writing control bit 2 as 1 empties the transmit FIFO at that edge. Afterwards `tx_data_req` is 1, and `tx_irq` is 1 if `tx_irq_en` is high. Writing bit 2 as 0 leaves the count unchanged.
- R9: Writing control bit 1 as 1 empties the receive FIFO at that edge.
- R10: `tx_load` is high, with the head byte on `tx_load_byte`, only when `tx_shift_busy` is low, the transmit FIFO is not empty and no transmit flush is being written. Each load removes one byte. Bytes flushed while the shifter is busy are never loaded.
- R11: Reserved control bits 31:8 and 5:4 have no effect. The flush bits act only on the write that carries them and are not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the shared control/identification address |
| bus_wdata | input | 32 | Control word written |
| bus_rdata | output | 32 | Identification word read |
| rx_irq_en | input | 1 | Receive-data-available interrupt enable |
| tx_irq_en | input | 1 | Transmit request interrupt enable |
| dma_mode | input | 1 | DMA requests enabled |
| rx_push | input | 1 | Push received byte |
| rx_byte | input | 8 | Received byte |
| rx_pop | input | 1 | Pop receive head |
| rx_head | output | 8 | Receive FIFO head byte |
| rx_level | output | 7 | Receive byte count |
| tx_push | input | 1 | Push byte to transmit |
| tx_byte | input | 8 | Byte to transmit |
| tx_shift_busy | input | 1 | Transmit shift register busy |
| tx_load | output | 1 | Byte handed to shift register this cycle |
| tx_load_byte | output | 8 | Byte handed to shift register |
| tx_level | output | 7 | Transmit byte count |
| tx_data_req | output | 1 | Transmit data request status |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Counts, control fields and flushes are registered. A push, pop or control write therefore shows on the levels and on every request line right after the next rising edge, and the requests follow the counts combinationally. `tx_load` is combinational on the same cycle's shifter-busy input and is consumed at the following edge. The bench drives on falling edges and samples status one falling edge later, after exactly one rising edge. A scoreboard monitor samples `tx_load` on the rising edge and checks each loaded byte against a queue filled by the push task.

// File: rtl/uart_fifo_pkg.sv
// Package: shared types and helpers for the UART FIFO threshold controller.
// Assumes control-word bit positions are fixed by software convention.
package uart_fifo_pkg;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_RXCLR_BIT = 1;
    localparam int CTL_TXCLR_BIT = 2;
    localparam int CTL_TXLVL_BIT = 3;
    localparam int CTL_TRIG_LO  = 6;

    typedef struct packed {
        logic [1:0] rx_trig;      // receive level code
        logic       tx_on_empty;  // 1: request only when empty
        logic       fifo_on;      // FIFOs enabled
    } fifo_ctl_t;

    // Byte count that a receive level code stands for.
    function automatic int trig_bytes(input logic [1:0] code);
        case (code)
            2'b00:   trig_bytes = 1;
            2'b01:   trig_bytes = 8;
            2'b10:   trig_bytes = 16;
            default: trig_bytes = 32;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
// Byte FIFO with flush and a single-entry mode.
// Assumes flush has priority over push and pop in the same cycle; pushes
// into a full FIFO and pops from an empty one are ignored.
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          single,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    // Effective capacity and accepted operations.
    always_comb begin
        cap     = single ? CW'(1) : CW'(DEPTH);
        do_push = push && (count < cap) && !clr;
        do_pop  = pop && (count != '0) && !clr;
    end

    // Next pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assign dout = mem[rd_ptr];

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    a_r3_single_holds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (single && count == CW'(1) && push && !pop && !clr) |=> (count == CW'(1)));

endmodule

// File: rtl/fifo_ctl_reg.sv
// Write-only control word sharing its address with a read-only ID word.
// Assumes reserved bits are dropped and flush bits act as one-cycle pulses.
module fifo_ctl_reg
    import uart_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output fifo_ctl_t   ctl,
    output logic        rx_flush,
    output logic        tx_flush,
    output logic [31:0] rdata
);
    // Stored fields only; reserved bits are never captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr) begin
            ctl.fifo_on     <= wdata[CTL_EN_BIT];
            ctl.tx_on_empty <= wdata[CTL_TXLVL_BIT];
            ctl.rx_trig     <= wdata[CTL_TRIG_LO +: 2];
        end
    end

    // Flush pulses exist only during the write that carries them.
    always_comb begin
        rx_flush = wr && wdata[CTL_RXCLR_BIT];
        tx_flush = wr && wdata[CTL_TXCLR_BIT];
    end

    // Placeholder identification word.
    always_comb begin
        rdata = 32'h0000_0001;
        rdata[7] = ctl.fifo_on;
        rdata[6] = ctl.fifo_on;
    end

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctl.fifo_on == $past(wdata[CTL_EN_BIT])));

endmodule

// File: rtl/req_gen.sv
// Interrupt and DMA request generation from FIFO occupancy.
// Assumes counts are registered so requests settle one edge after a change.
module req_gen
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_ctl_t     ctl,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] tx_cnt,
    input  logic          rx_irq_en,
    input  logic          tx_irq_en,
    input  logic          dma_mode,
    output logic          rx_irq,
    output logic          rx_dma,
    output logic          tx_req,
    output logic          tx_irq,
    output logic          tx_dma
);
    logic [CW-1:0] rx_thr;
    logic          rx_hit;

    // Receive level and comparison.
    always_comb begin
        rx_thr = ctl.fifo_on ? CW'(trig_bytes(ctl.rx_trig)) : CW'(1);
        rx_hit = rx_cnt >= rx_thr;
        rx_irq = rx_irq_en && rx_hit;
        rx_dma = dma_mode && ctl.fifo_on && (ctl.rx_trig != 2'b00) && rx_hit;
    end

    // Transmit level: half empty or empty.
    always_comb begin
        if (ctl.fifo_on && !ctl.tx_on_empty) tx_req = tx_cnt <= CW'(HALF);
        else                                 tx_req = tx_cnt == '0;
        tx_irq = tx_irq_en && tx_req;
        tx_dma = dma_mode && tx_req;
    end

    a_r6_trig1_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rx_trig == 2'b00) |-> !rx_dma);
    a_r7_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.tx_on_empty && tx_req) |-> (tx_cnt == '0));

endmodule

// File: rtl/uart_fifo_ctrl.sv
// Top: UART FIFO threshold controller.
// Assumes one shared bus address for control write and ID read, and an
// external shifter that accepts a byte whenever it reports not busy.
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          rx_irq_en,
    input  logic          tx_irq_en,
    input  logic          dma_mode,
    input  logic          rx_push,
    input  logic [W-1:0]  rx_byte,
    input  logic          rx_pop,
    output logic [W-1:0]  rx_head,
    output logic [CW-1:0] rx_level,
    input  logic          tx_push,
    input  logic [W-1:0]  tx_byte,
    input  logic          tx_shift_busy,
    output logic          tx_load,
    output logic [W-1:0]  tx_load_byte,
    output logic [CW-1:0] tx_level,
    output logic          tx_data_req,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);
    fifo_ctl_t ctl;
    logic      rx_flush, tx_flush;

    fifo_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
        .ctl(ctl), .rx_flush(rx_flush), .tx_flush(tx_flush), .rdata(bus_rdata)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .single(!ctl.fifo_on), .clr(rx_flush),
        .push(rx_push), .din(rx_byte), .pop(rx_pop),
        .dout(rx_head), .count(rx_level)
    );

    // Hand a byte to the shifter when idle, never during a flush.
    assign tx_load = !tx_shift_busy && (tx_level != '0) && !tx_flush;

    byte_fifo #(.DEPTH(DEPTH), .W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .single(!ctl.fifo_on), .clr(tx_flush),
        .push(tx_push), .din(tx_byte), .pop(tx_load),
        .dout(tx_load_byte), .count(tx_level)
    );

    req_gen #(.DEPTH(DEPTH)) u_req (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .rx_cnt(rx_level), .tx_cnt(tx_level),
        .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en), .dma_mode(dma_mode),
        .rx_irq(rx_irq), .rx_dma(rx_dma_req), .tx_req(tx_data_req),
        .tx_irq(tx_irq), .tx_dma(tx_dma_req)
    );

    a_r8_flush_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> tx_data_req);
    a_r9_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_level == '0));
    a_r10_load_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_push) |=> (tx_level == $past(tx_level) - CW'(1)));

endmodule

// File: tb/tb_uart_fifo_ctrl.sv
// Scoreboard bench for uart_fifo_ctrl: 250 MHz clock, drive on falling edge.
module tb_uart_fifo_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_irq_en = 0, tx_irq_en = 0, dma_mode = 0;
    logic        rx_push = 0, rx_pop = 0, tx_push = 0, tx_shift_busy = 1;
    logic [7:0]  rx_byte = '0, tx_byte = '0, rx_head, tx_load_byte;
    logic [6:0]  rx_level, tx_level;
    logic        tx_load, tx_data_req, rx_irq, tx_irq, rx_dma_req, tx_dma_req;

    int checks = 0, fails = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    always #2 clk = ~clk;

    uart_fifo_ctrl dut (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(logic [31:0] v);
        bus_wr = 1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rx_put(logic [7:0] b);
        rx_push = 1; rx_byte = b;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic tx_put(logic [7:0] b, bit keep);
        tx_push = 1; tx_byte = b;
        if (keep) exp_tx.push_back(b);
        @(negedge clk);
        tx_push = 0;
    endtask

    // Scoreboard monitor: every byte handed to the shifter must match.
    always @(posedge clk) begin
        if (rst_n && tx_load) begin
            checks++;
            if (exp_tx.size() == 0) begin
                fails++;
                $display("FAIL R10 actual=load %0h expected=no load", tx_load_byte);
            end else begin
                logic [7:0] e;
                e = exp_tx.pop_front();
                if (tx_load_byte != e) begin
                    fails++;
                    $display("FAIL R10 actual=%0h expected=%0h", tx_load_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 tx_data_req", tx_data_req, 1);
        chk("R1 rdata", bus_rdata, 32'h1);

        // R3 disabled: one byte each way
        rx_irq_en = 1;
        rx_put(8'h11); rx_put(8'h22);
        chk("R3 rx single", rx_level, 1);
        chk("R3 rx head", rx_head, 8'h11);
        chk("R5 irq at 1", rx_irq, 1);
        tx_put(8'h33, 0); tx_put(8'h44, 0);
        chk("R3 tx single", tx_level, 1);
        chk("R7 disabled needs empty", tx_data_req, 0);

        // R2 enable, then flush both
        wr_ctl(32'h01);
        chk("R2 rdata enabled", bus_rdata, 32'hC1);
        chk("R2 enable keeps data", rx_level, 1);
        wr_ctl(32'h07);
        chk("R9 rx flushed", rx_level, 0);
        chk("R8 tx flushed", tx_level, 0);
        wr_ctl(32'h01);

        // R5/R6/R11 levels 8,16,32 with reserved bits set
        dma_mode = 1;
        wr_ctl(32'hFFFF_FF71);
        chk("R11 reserved ignored rdata", bus_rdata, 32'hC1);
        for (int i = 0; i < 7; i++) begin rx_put(8'(i)); exp_rx.push_back(8'(i)); end
        chk("R5 7 of 8 irq", rx_irq, 0);
        chk("R6 7 of 8 dma", rx_dma_req, 0);
        rx_put(8'd7); exp_rx.push_back(8'd7);
        chk("R5 8 of 8 irq", rx_irq, 1);
        chk("R6 8 of 8 dma", rx_dma_req, 1);
        chk("R11 flush bits not held", rx_level, 8);
        wr_ctl(32'h81);
        chk("R5 8 of 16", rx_irq, 0);
        for (int i = 8; i < 16; i++) begin rx_put(8'(i)); exp_rx.push_back(8'(i)); end
        chk("R5 16 of 16", rx_irq, 1);
        wr_ctl(32'hC1);
        chk("R5 16 of 32", rx_irq, 0);
        for (int i = 16; i < 32; i++) begin rx_put(8'(i)); exp_rx.push_back(8'(i)); end
        chk("R5 32 of 32", rx_irq, 1);
        chk("R6 32 dma", rx_dma_req, 1);
        wr_ctl(32'h01);
        chk("R5 level 1 irq", rx_irq, 1);
        chk("R6 level 1 no dma", rx_dma_req, 0);

        // R4 order on drain
        for (int i = 0; i < 32; i++) begin
            logic [7:0] e;
            e = exp_rx.pop_front();
            chk("R4 rx order", rx_head, e);
            rx_pop = 1; @(negedge clk); rx_pop = 0;
        end
        chk("R4 drained", rx_level, 0);

        // R4 full drop
        for (int i = 0; i < 66; i++) rx_put(8'hA5);
        chk("R4 cap 64", rx_level, 64);
        wr_ctl(32'h03);
        chk("R9 flush full", rx_level, 0);
        chk("R9 irq drops", rx_irq, 0);

        // R7 transmit levels (shifter busy)
        tx_irq_en = 1;
        for (int i = 0; i < 32; i++) tx_put(8'h5A, 0);
        chk("R7 32 half", tx_data_req, 1);
        chk("R7 dma", tx_dma_req, 1);
        tx_put(8'h5A, 0);
        chk("R7 33 not half", tx_data_req, 0);
        chk("R7 irq low", tx_irq, 0);
        wr_ctl(32'h09);
        chk("R8 bit2 zero keeps", tx_level, 33);
        wr_ctl(32'h01);
        for (int i = 0; i < 2; i++) rx_put(8'h00);
        wr_ctl(32'h09);
        chk("R11 rx not flushed", rx_level, 2);
        wr_ctl(32'h0D);
        chk("R8 flushed", tx_level, 0);
        chk("R8 req", tx_data_req, 1);
        chk("R8 irq", tx_irq, 1);

        // R10 flush while busy: nothing loaded afterwards
        tx_put(8'h77, 0); tx_put(8'h78, 0);
        wr_ctl(32'h05);
        tx_shift_busy = 0;
        repeat (3) @(negedge clk);
        chk("R10 no load after flush", tx_load, 0);
        chk("R10 level", tx_level, 0);

        // R10 scoreboard drain to shifter
        tx_put(8'hC3, 1); tx_put(8'h3C, 1); tx_put(8'h96, 1);
        repeat (4) @(negedge clk);
        chk("R10 queue consumed", exp_tx.size(), 0);
        chk("R10 drained", tx_level, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule